// File: doc/BRIEF.md
# TDM Virtual FIFO Controller

This block keeps one logical FIFO for each channel of a time-division-multiplexed stream. All channels share a single data RAM. Each channel owns a fixed region of that RAM, addressed as `{channel, slot}`. A single write engine and a single read engine are time-shared across the channels. Each channel's head and tail pointers sit in two small pointer RAMs indexed by channel number, not in per-channel registers.

On every cycle the write side may deliver one word for the channel in the current TDM slot. The read side may serve one request for any channel. The bus feeding the block learns of back-pressure only after several cycles. For that reason each channel raises an almost-full flag once its free space falls to or below a programmable level. The remaining room then absorbs the words still in flight.

After a synchronous reset, the block steps through the pointer RAMs to clear every channel. Only after that sweep does it raise `ready`.

Top module: `tdm_vfifo`

## Requirements
- R1: After `rst` is released, `ready` stays low for exactly NUM_CH rising edges and is high after that. Once high, it stays high until the next reset. On the first ready cycle every channel reports `rd_empty`=1 and `wr_full`=0.
- R2: The words accepted for a channel are read back from that channel in the order they were written.
- R3: `wr_full` is high for `wr_ch` when that channel holds DEPTH (=2^DEPTH_LOG2) words. `rd_empty` is high for `rd_ch` when that channel holds 0 words. Both flags describe the state at the start of the current cycle.
- R4: A write (`wr_valid`=1) to a full channel is dropped and sets bit `wr_ch` of `overflow`. That bit stays set until the next reset.
- R5: A request (`rd_req`=1) to an empty channel is not served: `rd_valid` is 0 on the following cycle.
- R6: A served request produces `rd_valid`=1 and the head word on `rd_data` one cycle after the request.
- R7: `wr_afull` is 1 exactly when (DEPTH − count of `wr_ch`) ≤ `af_level`.
- R8: A write and a read to the same channel in the same cycle are both handled. Each is judged against the state at the start of that cycle: a write to a full channel is dropped even if the read succeeds, and a read of an empty channel fails even if the write succeeds.
- R9: While `ready` is 0, `wr_valid` and `rd_req` have no effect, and `rd_valid` remains 0.
- R10: Traffic on one channel never changes the count, data or flags of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ready | output | 1 | Pointer clearing finished |
| af_level | input | DEPTH_LOG2+1 | Almost-full free-space level |
| wr_valid | input | 1 | Write word present |
| wr_ch | input | log2(NUM_CH) | Channel of the current TDM slot |
| wr_data | input | DATA_W | Write word |
| wr_full | output | 1 | `wr_ch` is full |
| wr_afull | output | 1 | `wr_ch` is at or below the free-space level |
| overflow | output | NUM_CH | Sticky per-channel dropped-write bits |
| rd_req | input | 1 | Read request |
| rd_ch | input | log2(NUM_CH) | Channel requested |
| rd_empty | output | 1 | `rd_ch` is empty |
| rd_valid | output | 1 | `rd_data` holds a served word |
| rd_data | output | DATA_W | Word read |

## Verification
The bench first fills and drains each channel on its own, past both limits, while stepping `af_level` through every value from 0 to DEPTH. This separates the full, empty and almost-full thresholds from one another and exposes off-by-one errors in pointer wrap. Next comes a long pseudo-random stretch in which writes and reads land on the same channel or on different channels. That stretch separates correct pre-cycle arbitration and channel isolation from cross-channel pointer aliasing. Writes and reads are also issued during the reset sweep, and the overflow bits are checked across a second reset, which tells ignored stimulus apart from accepted stimulus.

// File: rtl/tdm_vfifo_pkg.sv
package tdm_vfifo_pkg;
   typedef enum logic {
      SWEEP_RUN  = 1'b0,
      SWEEP_DONE = 1'b1
   } sweep_state_e;
endpackage

// File: rtl/tdm_vfifo_ptr_ram.sv
module tdm_vfifo_ptr_ram #(
   parameter int ENTRIES = 8,
   parameter int WIDTH   = 5
) (
   input  logic                       clk,
   input  logic                       we,
   input  logic [$clog2(ENTRIES)-1:0] waddr,
   input  logic [WIDTH-1:0]           wdata,
   input  logic [$clog2(ENTRIES)-1:0] raddr_a,
   output logic [WIDTH-1:0]           rdata_a,
   input  logic [$clog2(ENTRIES)-1:0] raddr_b,
   output logic [WIDTH-1:0]           rdata_b
);
   logic [WIDTH-1:0] mem [ENTRIES];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata_a = mem[raddr_a];
   assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/tdm_vfifo_data_ram.sv
module tdm_vfifo_data_ram #(
   parameter int WORDS = 128,
   parameter int WIDTH = 8
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [$clog2(WORDS)-1:0] waddr,
   input  logic [WIDTH-1:0]         wdata,
   input  logic [$clog2(WORDS)-1:0] raddr,
   output logic [WIDTH-1:0]         rdata
);
   logic [WIDTH-1:0] mem [WORDS];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];
endmodule

// File: rtl/tdm_vfifo_sweep.sv
module tdm_vfifo_sweep
   import tdm_vfifo_pkg::*;
#(
   parameter int NUM_CH = 8
) (
   input  logic                      clk,
   input  logic                      rst,
   output logic                      busy,
   output logic [$clog2(NUM_CH)-1:0] sweep_ch,
   output logic                      ready
);
   localparam int CH_W = $clog2(NUM_CH);
   localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);
   localparam logic [CH_W-1:0] ONE_CH  = CH_W'(1);

   sweep_state_e state;

   always_ff @(posedge clk) begin
      if (rst) begin
         state    <= SWEEP_RUN;
         sweep_ch <= '0;
      end else if (state == SWEEP_RUN) begin
         sweep_ch <= sweep_ch + ONE_CH;
         if (sweep_ch == LAST_CH) state <= SWEEP_DONE;
      end
   end

   assign ready = (state == SWEEP_DONE);
   assign busy  = !ready;

   // R1
   ready_hold_chk: assert property (@(posedge clk) disable iff (rst)
      ready |=> ready);
endmodule

// File: rtl/tdm_vfifo.sv
module tdm_vfifo #(
   parameter int NUM_CH     = 8,
   parameter int DEPTH_LOG2 = 4,
   parameter int DATA_W     = 8
) (
   input  logic                      clk,
   input  logic                      rst,
   output logic                      ready,
   input  logic [DEPTH_LOG2:0]       af_level,
   input  logic                      wr_valid,
   input  logic [$clog2(NUM_CH)-1:0] wr_ch,
   input  logic [DATA_W-1:0]         wr_data,
   output logic                      wr_full,
   output logic                      wr_afull,
   output logic [NUM_CH-1:0]         overflow,
   input  logic                      rd_req,
   input  logic [$clog2(NUM_CH)-1:0] rd_ch,
   output logic                      rd_empty,
   output logic                      rd_valid,
   output logic [DATA_W-1:0]         rd_data
);
   localparam int CH_W  = $clog2(NUM_CH);
   localparam int DEPTH = 1 << DEPTH_LOG2;
   localparam int PTR_W = DEPTH_LOG2 + 1;
   localparam int WORDS = NUM_CH * DEPTH;
   localparam logic [PTR_W-1:0] WRAP_BIT = PTR_W'(DEPTH);
   localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);

   if (NUM_CH < 2 || NUM_CH > 32 || (1 << CH_W) != NUM_CH) begin : g_bad_ch
      $error("tdm_vfifo: NUM_CH must be a power of two from 2 to 32");
   end
   if (DEPTH_LOG2 < 1 || DEPTH_LOG2 > 8) begin : g_bad_depth
      $error("tdm_vfifo: DEPTH_LOG2 must be 1..8");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("tdm_vfifo: DATA_W must be positive");
   end

   logic             busy;
   logic [CH_W-1:0]  sweep_ch;
   logic [PTR_W-1:0] wp_at_w, wp_at_r, rp_at_w, rp_at_r;
   logic [PTR_W-1:0] used_w, free_w;
   logic             wr_take, rd_take;
   logic [DATA_W-1:0] head_word;

   tdm_vfifo_sweep #(.NUM_CH(NUM_CH)) u_sweep (
      .clk(clk), .rst(rst), .busy(busy), .sweep_ch(sweep_ch), .ready(ready)
   );

   // tail pointers: written only by the write engine (or the sweep)
   tdm_vfifo_ptr_ram #(.ENTRIES(NUM_CH), .WIDTH(PTR_W)) u_wptr (
      .clk(clk),
      .we(busy | wr_take),
      .waddr(busy ? sweep_ch : wr_ch),
      .wdata(busy ? '0 : wp_at_w + PTR_ONE),
      .raddr_a(wr_ch), .rdata_a(wp_at_w),
      .raddr_b(rd_ch), .rdata_b(wp_at_r)
   );

   // head pointers: written only by the read engine (or the sweep)
   tdm_vfifo_ptr_ram #(.ENTRIES(NUM_CH), .WIDTH(PTR_W)) u_rptr (
      .clk(clk),
      .we(busy | rd_take),
      .waddr(busy ? sweep_ch : rd_ch),
      .wdata(busy ? '0 : rp_at_r + PTR_ONE),
      .raddr_a(wr_ch), .rdata_a(rp_at_w),
      .raddr_b(rd_ch), .rdata_b(rp_at_r)
   );

   tdm_vfifo_data_ram #(.WORDS(WORDS), .WIDTH(DATA_W)) u_data (
      .clk(clk),
      .we(wr_take),
      .waddr({wr_ch, wp_at_w[DEPTH_LOG2-1:0]}),
      .wdata(wr_data),
      .raddr({rd_ch, rp_at_r[DEPTH_LOG2-1:0]}),
      .rdata(head_word)
   );

   assign used_w   = wp_at_w - rp_at_w;
   assign free_w   = WRAP_BIT - used_w;
   assign wr_full  = ready && (wp_at_w == (rp_at_w ^ WRAP_BIT));
   assign wr_afull = ready && (free_w <= af_level);
   assign rd_empty = !ready || (wp_at_r == rp_at_r);
   assign wr_take  = ready && wr_valid && !wr_full;
   assign rd_take  = ready && rd_req && !rd_empty;

   always_ff @(posedge clk) begin
      if (rst) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_take;
         if (rd_take) rd_data <= head_word;
      end
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ovf
      logic hit;
      assign hit = ready && wr_valid && wr_full && (wr_ch == CH_W'(c));
      always_ff @(posedge clk) begin
         if (rst) overflow[c] <= 1'b0;
         else if (hit) overflow[c] <= 1'b1;
      end

      // R4
      ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
         overflow[c] |=> overflow[c]);
   end

   // R9
   idle_no_read_chk: assert property (@(posedge clk) disable iff (rst)
      !ready |=> !rd_valid);

   // R7
   full_implies_afull_chk: assert property (@(posedge clk) disable iff (rst)
      wr_full |-> wr_afull);

   // R3
   full_empty_excl_chk: assert property (@(posedge clk) disable iff (rst)
      (ready && wr_ch == rd_ch) |-> !(wr_full && rd_empty));

   // R4
   drop_marks_chk: assert property (@(posedge clk) disable iff (rst)
      (ready && wr_valid && wr_full) |=> (overflow != '0));
endmodule

// File: tb/tdm_vfifo_test.sv
module tdm_vfifo_test;
   localparam int NCH = 4;
   localparam int DL2 = 2;
   localparam int DEP = 1 << DL2;
   localparam int DW  = 8;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ready;
   logic [DL2:0] af_level = '0;
   logic wr_valid = 1'b0;
   logic [1:0] wr_ch = '0;
   logic [DW-1:0] wr_data = '0;
   logic wr_full, wr_afull;
   logic [NCH-1:0] overflow;
   logic rd_req = 1'b0;
   logic [1:0] rd_ch = '0;
   logic rd_empty, rd_valid;
   logic [DW-1:0] rd_data;

   int checks = 0;
   int errors = 0;

   logic [DW-1:0] mq [NCH][DEP];
   int mhead [NCH];
   int mcnt  [NCH];
   logic [NCH-1:0] movf;

   always #4 clk = ~clk;

   tdm_vfifo #(.NUM_CH(NCH), .DEPTH_LOG2(DL2), .DATA_W(DW)) uut (
      .clk(clk), .rst(rst), .ready(ready), .af_level(af_level),
      .wr_valid(wr_valid), .wr_ch(wr_ch), .wr_data(wr_data),
      .wr_full(wr_full), .wr_afull(wr_afull), .overflow(overflow),
      .rd_req(rd_req), .rd_ch(rd_ch), .rd_empty(rd_empty),
      .rd_valid(rd_valid), .rd_data(rd_data)
   );

   task automatic chk(input bit ok, input string req, input int got, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s got %0d exp %0d", req, got, exp);
      end
   endtask

   task automatic model_clear();
      for (int c = 0; c < NCH; c++) begin
         mhead[c] = 0;
         mcnt[c]  = 0;
      end
      movf = '0;
   endtask

   // one cycle: drive at negedge, check flags, then check the registered read
   task automatic cyc(input bit wv, input int wc, input int wd,
                      input bit rq, input int rc, input int af);
      bit ef, ee, ea, aw, ar;
      logic [DW-1:0] ed;
      int wpos;
      @(negedge clk);
      wr_valid = wv; wr_ch = 2'(wc); wr_data = DW'(wd);
      rd_req = rq; rd_ch = 2'(rc); af_level = (DL2+1)'(af);
      #1;
      ef = (mcnt[wc] == DEP);
      ee = (mcnt[rc] == 0);
      ea = ((DEP - mcnt[wc]) <= af);
      chk(wr_full == ef, "R3 full", int'(wr_full), int'(ef));
      chk(rd_empty == ee, "R3 empty", int'(rd_empty), int'(ee));
      chk(wr_afull == ea, "R7 afull", int'(wr_afull), int'(ea));
      chk(overflow == movf, "R4 overflow", int'(overflow), int'(movf));
      aw = wv && !ef;
      ar = rq && !ee;
      ed = mq[rc][mhead[rc]];
      wpos = (mhead[wc] + mcnt[wc]) % DEP;
      @(posedge clk);
      #1;
      // R5 R6 R8
      chk(rd_valid == ar, "R6 rd_valid", int'(rd_valid), int'(ar));
      if (ar) chk(rd_data == ed, "R2 order", int'(rd_data), int'(ed));
      if (ar) begin
         mhead[rc] = (mhead[rc] + 1) % DEP;
         mcnt[rc]--;
      end
      if (aw) begin
         mq[wc][wpos] = DW'(wd);
         mcnt[wc]++;
      end
      if (wv && ef) movf[wc] = 1'b1;
   endtask

   task automatic do_reset(input bit poke);
      int n;
      @(negedge clk);
      rst = 1'b1;
      wr_valid = poke; rd_req = poke; wr_data = 8'hA5;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      n = 0;
      while (n < 100) begin
         @(posedge clk);
         #1;
         n++;
         if (ready) break;
         // R9
         chk(!rd_valid, "R9 no read while sweeping", int'(rd_valid), 0);
         wr_ch = 2'(n); rd_ch = 2'(n);
      end
      wr_valid = 1'b0; rd_req = 1'b0;
      chk(n == NCH, "R1 sweep length", n, NCH);
      model_clear();
   endtask

   logic [15:0] lfsr = 16'hACE1;
   int seq = 0;

   initial begin
      model_clear();
      do_reset(1'b1);
      // R1 R9: all channels empty, not full, no overflow after sweep
      for (int c = 0; c < NCH; c++) cyc(1'b0, c, 0, 1'b0, c, 0);

      // fill/drain sweep per channel and per almost-full level (R3 R4 R5 R7 R10)
      for (int af = 0; af <= DEP; af++) begin
         for (int c = 0; c < NCH; c++) begin
            for (int k = 0; k <= DEP; k++) begin
               seq++;
               cyc(1'b1, c, seq, 1'b0, (c + 1) % NCH, af);
            end
            for (int k = 0; k <= DEP; k++) cyc(1'b0, c, 0, 1'b1, c, af);
         end
      end

      // mixed traffic, frequent same-channel collisions (R2 R8 R10)
      for (int i = 0; i < 3000; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         seq++;
         cyc(lfsr[0] | lfsr[5], int'(lfsr[2:1]), seq,
             lfsr[3] | lfsr[8], lfsr[9] ? int'(lfsr[2:1]) : int'(lfsr[7:6]),
             int'(lfsr[12:10]) % (DEP + 1));
      end

      // R4: overflow bits clear only on reset
      do_reset(1'b0);
      for (int c = 0; c < NCH; c++) cyc(1'b0, c, 0, 1'b1, c, DEP);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog got 0 exp 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule